// File: doc/BRIEF.md
# Dual-Clock FIFO with Request/Acknowledge Write Port

This block carries fixed-width data words from a producer clocked by one clock to a consumer clocked by a second clock that has no phase or frequency relation to the first. Words are held in a register array that the write clock fills and the read clock drains at the same time. No arbitration between the two sides is needed.

The producer offers a word by raising a request with the data. The block takes the word only when it has room, and answers with an acknowledge. The exchange is four-phase: acknowledge stays high until request falls. The consumer sees an empty flag and a show-ahead data output, and it pops the head word with a read enable.

Each side keeps a binary pointer one bit wider than the address. It also registers a Gray-coded copy of that pointer. The Gray copy crosses to the other side through a flip-flop chain of configurable length, and each flag is built from the local pointer and the synchronized remote pointer. Each side has its own asynchronous active-low reset. The two resets must be asserted together and released synchronously to their own clocks.

Top module: `cdc_queue`

## Requirements
- R1: While either reset is low, and after both resets are released with no write yet, `rd_empty` is 1 and `wr_ack` is 0.
- R2: A word is stored exactly when `wr_ack` rises. The first write-clock edge that sees `wr_req`=1, `wr_ack`=0 and free space raises `wr_ack`, and `wr_data` is captured at that edge. `wr_ack` stays 1 while `wr_req` stays 1, and it falls on the first edge that sees `wr_req`=0. No further word is taken until `wr_ack` has returned to 0.
- R3: The block never holds more than DEPTH = 2^ADDR_W words. If a request arrives while DEPTH words are stored, it gets no acknowledge and stores nothing.
- R4: After a write into an empty FIFO, `rd_empty` falls only after at least SYNC_STAGES read-clock rising edges have followed the acknowledging write edge.
- R5: A read enable seen while `rd_empty`=1 is ignored. The read pointer and the stored words stay unchanged, and `rd_empty` stays 1.
- R6: Words come out on `rd_data` in the order in which they were acknowledged, with unchanged values. `rd_data` shows the head word whenever `rd_empty`=0, and `rd_en`=1 at a read-clock edge removes it.
- R7: A request held while the FIFO is full is acknowledged once reads have freed space and the freed space has become visible through the read-to-write synchronizer.
- R8: Each Gray pointer changes in at most one bit per edge of its own clock.
- R9: After one write followed by one read, `rd_empty` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst_n | input | 1 | Producer-side asynchronous active-low reset |
| wr_req | input | 1 | Producer offers the word on wr_data |
| wr_data | input | DATA_W | Word offered by the producer |
| wr_ack | output | 1 | Word taken; held high until wr_req falls |
| rd_clk | input | 1 | Consumer clock |
| rd_rst_n | input | 1 | Consumer-side asynchronous active-low reset |
| rd_en | input | 1 | Pop the head word at the next read-clock edge |
| rd_data | output | DATA_W | Head word (valid while rd_empty is 0) |
| rd_empty | output | 1 | No word visible to the consumer |

## Verification
The hardest state to reach is a request stalled on a full buffer that is then released by the consumer. Reaching it takes DEPTH acknowledged words while the consumer is idle, an extra request left pending, and then reads restarted. The stall is only released after the freed slot has passed through the read-to-write synchronizer. The bench builds this sequence on purpose and then checks that the held word arrives in order. A separate phase keeps the read enable high against an empty buffer and checks that the stalled reads neither move the pointer nor disturb the later data. The last phase runs long mixed bursts at two unrelated clock periods against a reference queue.

// File: rtl/cdcq_pkg.sv
package cdcq_pkg;

  function automatic logic [15:0] to_gray(input logic [15:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [15:0] from_gray(input logic [15:0] g);
    logic [15:0] b;
    b[15] = g[15];
    for (int i = 14; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/cdcq_sync.sv
module cdcq_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cdcq_store.sv
module cdcq_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/cdcq_wr_side.sv
module cdcq_wr_side
  import cdcq_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int PW    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  output logic              ack,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [PW-1:0]     gray,
  input  logic [PW-1:0]     rgray_sync
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [PW-1:0] bin_q, bin_d, gray_d;
  logic          ack_d, full, take;

  assign full = (gray[PW-1:PW-2] == ~rgray_sync[PW-1:PW-2]) &&
                (gray[PW-3:0] == rgray_sync[PW-3:0]);

  always_comb begin
    take   = req && !ack && !full;
    bin_d  = take ? bin_q + 1'b1 : bin_q;
    gray_d = PW'(to_gray(16'(bin_d)));
    if (!ack) ack_d = take;
    else      ack_d = req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q <= '0;
      gray  <= '0;
      ack   <= 1'b0;
    end else begin
      bin_q <= bin_d;
      gray  <= gray_d;
      ack   <= ack_d;
    end
  end

  assign we    = take;
  assign waddr = bin_q[ADDR_W-1:0];

  logic [PW-1:0] rbin_seen;
  assign rbin_seen = PW'(from_gray(16'(rgray_sync)));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, bin_q - rbin_seen}) <= (PW+1)'(DEPTH));
  assert_ack_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req) |=> ack);
  assert_ack_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !req) |=> !ack);
  assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !ack) |=> $stable(bin_q));
  assert_gray_step_wr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray ^ $past(gray)) <= 1);
endmodule

// File: rtl/cdcq_rd_side.sv
module cdcq_rd_side
  import cdcq_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int PW    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  output logic              empty,
  output logic [ADDR_W-1:0] raddr,
  output logic [PW-1:0]     gray,
  input  logic [PW-1:0]     wgray_sync
);
  logic [PW-1:0] bin_q, bin_d, gray_d;
  logic          pop;

  assign empty = (gray == wgray_sync);

  always_comb begin
    pop    = en && !empty;
    bin_d  = pop ? bin_q + 1'b1 : bin_q;
    gray_d = PW'(to_gray(16'(bin_d)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q <= '0;
      gray  <= '0;
    end else begin
      bin_q <= bin_d;
      gray  <= gray_d;
    end
  end

  assign raddr = bin_q[ADDR_W-1:0];

  assert_empty_in_reset_R1: assert property (@(posedge clk)
    !rst_n |-> empty);
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    empty |=> $stable(bin_q));
  assert_gray_step_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray ^ $past(gray)) <= 1);
endmodule

// File: rtl/cdc_queue.sv
module cdc_queue #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ack,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_empty
);
  localparam int PW = ADDR_W + 1;

  logic              we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wgray_rd, rgray_wr;

  cdcq_wr_side #(.ADDR_W(ADDR_W)) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .req(wr_req), .ack(wr_ack),
    .we(we), .waddr(waddr), .gray(wgray), .rgray_sync(rgray_wr)
  );

  cdcq_rd_side #(.ADDR_W(ADDR_W)) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .en(rd_en), .empty(rd_empty),
    .raddr(raddr), .gray(rgray), .wgray_sync(wgray_rd)
  );

  cdcq_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray), .q(wgray_rd)
  );

  cdcq_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray), .q(rgray_wr)
  );

  cdcq_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(rd_data)
  );
endmodule

// File: tb/cdc_queue_bench.sv
module cdc_queue_bench;
  localparam int DW = 8, AW = 3, NS = 2, DEPTH = 1 << AW;

  logic wr_clk = 0, rd_clk = 0, wr_rst_n = 0, rd_rst_n = 0;
  logic wr_req = 0, rd_en = 0, wr_ack, rd_empty;
  logic [DW-1:0] wr_data = '0, rd_data;

  int errors = 0, checks = 0;
  logic [DW-1:0] model [$];
  logic rd_active = 0, rd_random = 0;
  int lat_cnt = 0, lat_seen = -1;
  logic lat_armed = 0;

  always #5    wr_clk = ~wr_clk;
  always #6.85 rd_clk = ~rd_clk;

  cdc_queue #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(NS)) u_cdc_queue (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_req(wr_req), .wr_data(wr_data),
    .wr_ack(wr_ack), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_en(rd_en),
    .rd_data(rd_data), .rd_empty(rd_empty)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // R4 latency probe: count read edges after the acknowledging write edge
  always @(posedge wr_ack) if (lat_armed) lat_cnt = 0;
  always @(posedge rd_clk) if (lat_armed) lat_cnt++;
  always @(negedge rd_empty) if (lat_armed) begin
    lat_seen = lat_cnt;
    lat_armed = 0;
  end

  // Reader and per-clock reference comparison (R5, R6)
  initial forever begin
    @(negedge rd_clk);
    rd_en = 0;
    if (rd_rst_n) begin
      if (model.size() == 0)
        check(rd_empty == 1'b1, "R5 empty while model empty", rd_empty, 1);
      if (rd_active && (!rd_random || ($urandom_range(0, 3) != 0))) begin
        rd_en = 1;
        if (!rd_empty) begin
          check(model.size() > 0, "R6 data beyond model", 0, 1);
          if (model.size() > 0) begin
            check(rd_data == model[0], "R6 order/value", rd_data, model[0]);
            void'(model.pop_front());
          end
        end
      end
    end
  end

  task automatic push_word(input logic [DW-1:0] d, input int hold, input int limit,
                           output bit got);
    got = 0;
    @(negedge wr_clk);
    wr_req = 1; wr_data = d;
    for (int i = 0; i < limit; i++) begin
      @(negedge wr_clk);
      if (wr_ack) begin got = 1; break; end
    end
    if (!got) return;
    model.push_back(d);
    for (int i = 0; i < hold; i++) begin
      @(negedge wr_clk);
      check(wr_ack == 1'b1, "R2 ack held while req high", wr_ack, 1);
    end
    wr_req = 0; wr_data = ~d;
    @(negedge wr_clk);
    check(wr_ack == 1'b0, "R2 ack falls after req drops", wr_ack, 0);
  endtask

  initial begin
    bit got;
    int n;
    #10000000;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit got;
    repeat (3) @(negedge wr_clk);
    check(rd_empty == 1'b1, "R1 empty in reset", rd_empty, 1);
    check(wr_ack == 1'b0, "R1 ack low in reset", wr_ack, 0);
    @(negedge wr_clk); wr_rst_n = 1;
    @(negedge rd_clk); rd_rst_n = 1;
    repeat (4) @(negedge rd_clk);
    check(rd_empty == 1'b1, "R1 empty after reset", rd_empty, 1);
    check(wr_ack == 1'b0, "R1 ack low after reset", wr_ack, 0);

    // R4 latency, then R9 one write one read
    lat_armed = 1;
    push_word(8'hA5, 3, 20, got);
    check(got, "R2 first word acked", got, 1);
    repeat (10) @(negedge rd_clk);
    check(lat_seen >= NS, "R4 empty fall latency", lat_seen, NS);
    rd_active = 1;
    repeat (3) @(negedge rd_clk);
    check(rd_empty == 1'b1, "R9 empty after write+read", rd_empty, 1);

    // R5 reads held high against an empty FIFO, then data still correct
    repeat (20) @(negedge rd_clk);
    check(rd_empty == 1'b1, "R5 empty unchanged by stalled reads", rd_empty, 1);
    rd_active = 0;
    push_word(8'h3C, 0, 20, got);
    repeat (8) @(negedge rd_clk);
    check(rd_empty == 1'b0, "R5 word visible after stalled reads", rd_empty, 0);
    check(rd_data == 8'h3C, "R5 head word intact", rd_data, 8'h3C);

    // R3 fill to DEPTH (one word already stored), extra request stalls
    for (int i = 1; i < DEPTH; i++) begin
      push_word(8'(8'h10 + i), 0, 30, got);
      check(got, "R3 word accepted below depth", got, 1);
    end
    push_word(8'hEE, 0, 40, got);
    check(!got, "R3 no ack while full", got, 0);
    check(model.size() == DEPTH, "R3 stored count", model.size(), DEPTH);

    // R7 release stalled request by reading
    rd_active = 1;
    got = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge wr_clk);
      if (wr_ack) begin got = 1; break; end
    end
    check(got, "R7 held request acked after reads", got, 1);
    if (got) model.push_back(8'hEE);
    wr_req = 0;
    @(negedge wr_clk);
    check(wr_ack == 1'b0, "R2 ack falls after release", wr_ack, 0);
    repeat (40) @(negedge rd_clk);
    check(model.size() == 0, "R6 drained after release", model.size(), 0);

    // R6 mixed random traffic
    rd_random = 1;
    for (int i = 0; i < 300; i++) begin
      push_word(8'($urandom), $urandom_range(0, 2), 200, got);
      check(got, "R6 random word acked", got, 1);
      repeat ($urandom_range(0, 3)) @(negedge wr_clk);
    end
    repeat (80) @(negedge rd_clk);
    check(model.size() == 0, "R6 all words delivered", model.size(), 0);
    check(rd_empty == 1'b1, "R9 empty at end", rd_empty, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule